// File: doc/BRIEF.md
# Flash ISP Command Sequencer

This block accepts in-system-programming requests for an on-chip flash through a small synchronous register port and carries them out against an internal word array. Software loads a byte address, a 32-bit data word and a 7-bit command code, then writes 1 to the trigger bit. The sequencer checks the request before it touches the array. A legal request runs for a fixed, per-command number of cycles. An illegal request ends at once with a sticky fail flag and leaves the array untouched.

Three operations reach the array: word read, 32-bit program and page erase. Program ANDs the new word into the stored one, so bits only go from 1 to 0. Erase returns every word of a page to all ones. The read commands for the three identification words return fixed values set by parameter. Brown-out and "executing from application flash" conditions come in as plain input pins. Status shows busy, fail, a done interrupt flag and a conflict flag. The conflict flag records a register write made while an operation is running.

Register offsets (byte address on `bus_addr_i`): 0x00 control, 0x04 address, 0x08 data, 0x0C command, 0x10 trigger, 0x14 status.

Top module: `isp_seq`

## Requirements
- R1: After reset all registers read 0 and every flash word holds 0xFFFFFFFF. Writing 1 to trigger bit 0 while unlocked and idle, with a legal request, sets busy. Busy reads 1 on trigger bit 0 and status bit 0 for RD_CYC cycles (read, ID reads, reserved codes), PRG_CYC cycles (program) or ERS_CYC cycles (erase), then clears itself.
- R2: The command field (command register bits 6:0) accepts 0x00 read, 0x04 unique ID, 0x0B company ID, 0x0C device ID, 0x21 program and 0x22 page erase. Codes 0x08, 0x0D, 0x28 and 0x2D belong to a companion engine: they run for RD_CYC cycles with no flash action and no fail. Any other code sets fail (status bit 1) with no busy.
- R3: For read, program and erase, address bits 1:0 other than 00, or an address of WORDS*4 or more, set fail at once. No flash action occurs and the data register is unchanged.
- R4: Program takes its word from the data register and stores the bitwise AND of that word and the old contents at the addressed word.
- R5: Page erase sets all PAGE_WORDS words of the page containing the address to 0xFFFFFFFF and leaves other pages unchanged.
- R6: Read places the addressed word into the data register when busy clears. The ID reads place UID_VAL, CID_VAL or DID_VAL there.
- R7: Program or erase sets fail with no flash action in two cases: when `brownout_i` is 1, or when `app_exec_i` is 1 while update enable (control bit 1) is 0. Reads are not affected by either input.
- R8: Fail is sticky. It clears only when status is written with bit 1 set. Status bits 2 and 3 also clear on a write of 1.
- R9: While busy, a write to the address, data or command register, or an unlocked write to the trigger, is dropped. It sets conflict (status bit 3) and fail. The running operation still completes.
- R10: The interrupt flag (status bit 2) sets when an operation completes or when fail is set. `irq_o` equals the flag ANDed with interrupt enable (control bit 0).
- R11: Writes to control and trigger while `unlock_i` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| unlock_i | input | 1 | Write-protect unlock for control and trigger |
| brownout_i | input | 1 | Supply brown-out indication |
| app_exec_i | input | 1 | CPU executing from application flash |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the sequencer with WORDS=16 and PAGE_WORDS=4, so the last legal word (0x3C) and the first out-of-range address (0x40) are a few writes away. With those values a single erase can be checked against a neighbouring page. Latencies of 2, 3 and 5 cycles give each class a distinct busy length that the bench measures cycle by cycle. The erase window is long enough for a conflicting write to land while busy.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [5:0] OFS_CTRL = 6'h00;
  localparam logic [5:0] OFS_ADDR = 6'h04;
  localparam logic [5:0] OFS_DATA = 6'h08;
  localparam logic [5:0] OFS_CMD  = 6'h0C;
  localparam logic [5:0] OFS_GO   = 6'h10;
  localparam logic [5:0] OFS_STAT = 6'h14;

  localparam logic [6:0] CMD_READ  = 7'h00;
  localparam logic [6:0] CMD_UID   = 7'h04;
  localparam logic [6:0] CMD_CID   = 7'h0B;
  localparam logic [6:0] CMD_DID   = 7'h0C;
  localparam logic [6:0] CMD_PROG  = 7'h21;
  localparam logic [6:0] CMD_ERASE = 7'h22;
  localparam logic [6:0] CMD_EXT0  = 7'h08;
  localparam logic [6:0] CMD_EXT1  = 7'h0D;
  localparam logic [6:0] CMD_EXT2  = 7'h28;
  localparam logic [6:0] CMD_EXT3  = 7'h2D;

  typedef enum logic [2:0] {
    OP_NOP, OP_READ, OP_PROG, OP_ERASE, OP_UID, OP_CID, OP_DID
  } isp_op_e;
endpackage

// File: rtl/isp_check.sv
module isp_check
  import isp_pkg::*;
#(
  parameter int WORDS = 64
) (
  input  logic [6:0]  cmd_i,
  input  logic [31:0] addr_i,
  input  logic        brownout_i,
  input  logic        app_exec_i,
  input  logic        upd_en_i,
  output isp_op_e     op_o,
  output logic        fail_o
);
  localparam logic [31:0] ADDR_LIM = 32'(WORDS * 4);

  logic bad_code, touches_array, modifies;

  always_comb begin
    bad_code = 1'b0;
    op_o     = OP_NOP;
    unique case (cmd_i)
      CMD_READ:  op_o = OP_READ;
      CMD_UID:   op_o = OP_UID;
      CMD_CID:   op_o = OP_CID;
      CMD_DID:   op_o = OP_DID;
      CMD_PROG:  op_o = OP_PROG;
      CMD_ERASE: op_o = OP_ERASE;
      CMD_EXT0, CMD_EXT1, CMD_EXT2, CMD_EXT3: op_o = OP_NOP;
      default:   bad_code = 1'b1;
    endcase
  end

  assign touches_array = (op_o == OP_READ) || (op_o == OP_PROG) || (op_o == OP_ERASE);
  assign modifies      = (op_o == OP_PROG) || (op_o == OP_ERASE);

  assign fail_o = bad_code
               || (touches_array && ((addr_i[1:0] != 2'b00) || (addr_i >= ADDR_LIM)))
               || (modifies && (brownout_i || (app_exec_i && !upd_en_i)));
endmodule

// File: rtl/isp_array.sv
module isp_array #(
  parameter int WORDS      = 64,
  parameter int PAGE_WORDS = 8,
  localparam int IDX_W     = $clog2(WORDS),
  localparam int PAGE_W    = $clog2(PAGE_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_i,
  input  logic             erase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic hit_word, hit_page;
    assign hit_word = (idx_i == MY_IDX);
    assign hit_page = ((idx_i >> PAGE_W) == (MY_IDX >> PAGE_W));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 mem[g] <= '1;
      else if (erase_i && hit_page) mem[g] <= '1;
      else if (prog_i && hit_word)  mem[g] <= mem[g] & wdata_i;
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import isp_pkg::*;
#(
  parameter int          WORDS      = 64,
  parameter int          PAGE_WORDS = 8,
  parameter int          RD_CYC     = 2,
  parameter int          PRG_CYC    = 4,
  parameter int          ERS_CYC    = 8,
  parameter logic [31:0] UID_VAL    = 32'h5A17_C3E9,
  parameter logic [31:0] CID_VAL    = 32'h0000_00DA,
  parameter logic [31:0] DID_VAL    = 32'h0123_4567
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [5:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        unlock_i,
  input  logic        brownout_i,
  input  logic        app_exec_i,
  output logic        irq_o
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int CNT_W = $clog2(ERS_CYC + 1);

  logic        int_en_q, upd_en_q, busy_q, fail_q, intf_q, cerr_q;
  logic [31:0] addr_q, data_q;
  logic [6:0]  cmd_q;
  logic [CNT_W-1:0] cnt_q;
  isp_op_e     op_q, chk_op;
  logic        chk_fail;

  // write decode
  logic wr_ctrl, wr_go, wr_stat, wr_regs, conflict, start_req, start, start_bad, done;
  assign wr_ctrl   = bus_we_i && (bus_addr_i == OFS_CTRL) && unlock_i;
  assign wr_go     = bus_we_i && (bus_addr_i == OFS_GO) && unlock_i;
  assign wr_stat   = bus_we_i && (bus_addr_i == OFS_STAT);
  assign wr_regs   = bus_we_i && ((bus_addr_i == OFS_ADDR) || (bus_addr_i == OFS_DATA)
                                  || (bus_addr_i == OFS_CMD));
  assign conflict  = busy_q && (wr_regs || wr_go);
  assign start_req = wr_go && !busy_q && bus_wdata_i[0];
  assign start     = start_req && !chk_fail;
  assign start_bad = start_req && chk_fail;
  assign done      = busy_q && (cnt_q == '0);

  isp_check #(.WORDS(WORDS)) i_check (
    .cmd_i      (cmd_q),
    .addr_i     (addr_q),
    .brownout_i (brownout_i),
    .app_exec_i (app_exec_i),
    .upd_en_i   (upd_en_q),
    .op_o       (chk_op),
    .fail_o     (chk_fail)
  );

  logic [31:0] arr_rdata;
  isp_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)) i_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prog_i  (done && (op_q == OP_PROG)),
    .erase_i (done && (op_q == OP_ERASE)),
    .idx_i   (addr_q[IDX_W+1:2]),
    .wdata_i (data_q),
    .rdata_o (arr_rdata)
  );

  logic [CNT_W-1:0] lat_load;
  always_comb begin
    unique case (chk_op)
      OP_PROG:  lat_load = CNT_W'(PRG_CYC - 1);
      OP_ERASE: lat_load = CNT_W'(ERS_CYC - 1);
      default:  lat_load = CNT_W'(RD_CYC - 1);
    endcase
  end

  logic        res_vld;
  logic [31:0] res_val;
  always_comb begin
    res_vld = 1'b1;
    unique case (op_q)
      OP_READ: res_val = arr_rdata;
      OP_UID:  res_val = UID_VAL;
      OP_CID:  res_val = CID_VAL;
      OP_DID:  res_val = DID_VAL;
      default: begin res_val = arr_rdata; res_vld = 1'b0; end
    endcase
  end

  logic fail_set;
  assign fail_set = start_bad || conflict;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_en_q <= 1'b0;
      upd_en_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      cmd_q    <= '0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      op_q     <= OP_NOP;
      fail_q   <= 1'b0;
      intf_q   <= 1'b0;
      cerr_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        int_en_q <= bus_wdata_i[0];
        upd_en_q <= bus_wdata_i[1];
      end
      if (wr_regs && !busy_q) begin
        if (bus_addr_i == OFS_ADDR) addr_q <= bus_wdata_i;
        if (bus_addr_i == OFS_DATA) data_q <= bus_wdata_i;
        if (bus_addr_i == OFS_CMD)  cmd_q  <= bus_wdata_i[6:0];
      end
      if (done && res_vld) data_q <= res_val;

      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= lat_load;
        op_q   <= chk_op;
      end else if (done) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end

      // set wins over write-1-to-clear
      if (fail_set)                       fail_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[1]) fail_q <= 1'b0;
      if (fail_set || done)               intf_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[2]) intf_q <= 1'b0;
      if (conflict)                       cerr_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[3]) cerr_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      OFS_CTRL: bus_rdata_o = {30'd0, upd_en_q, int_en_q};
      OFS_ADDR: bus_rdata_o = addr_q;
      OFS_DATA: bus_rdata_o = data_q;
      OFS_CMD:  bus_rdata_o = {25'd0, cmd_q};
      OFS_GO:   bus_rdata_o = {31'd0, busy_q};
      OFS_STAT: bus_rdata_o = {28'd0, cerr_q, intf_q, fail_q, busy_q};
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = intf_q && int_en_q;
endmodule

// File: rtl/isp_seq_chk.sv
module isp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we,
  input logic [5:0] addr,
  input logic [1:0] wdata,
  input logic       unlock,
  input logic       busy,
  input logic       fail,
  input logic       intf,
  input logic       cerr,
  input logic       int_en,
  input logic       chk_fail,
  input logic       irq
);
  assert_busy_done_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> intf);

  assert_bad_go_no_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr == 6'h10 && unlock && !busy && wdata[0] && chk_fail) |=> (fail && !busy));

  assert_fail_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail && !(we && addr == 6'h14 && wdata[1])) |=> fail);

  assert_conflict_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we && (addr == 6'h04 || addr == 6'h08 || addr == 6'h0C)) |=> (cerr && fail));

  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> (int_en && intf));

  assert_ctrl_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && addr == 6'h00 && !unlock) |=> $stable(int_en));
endmodule

bind isp_seq isp_seq_chk i_isp_seq_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we       (bus_we_i),
  .addr     (bus_addr_i),
  .wdata    (bus_wdata_i[1:0]),
  .unlock   (unlock_i),
  .busy     (busy_q),
  .fail     (fail_q),
  .intf     (intf_q),
  .cerr     (cerr_q),
  .int_en   (int_en_q),
  .chk_fail (chk_fail),
  .irq      (irq_o)
);

// File: tb/test_isp_seq.sv
`timescale 1ns/1ps
module test_isp_seq;
  localparam logic [31:0] UID = 32'h5A17_C3E9;
  localparam logic [31:0] CID = 32'h0000_00DA;
  localparam logic [31:0] DID = 32'h0123_4567;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        unlock_i = 1'b1;
  logic        brownout_i = 1'b0;
  logic        app_exec_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;
  logic done_flag = 1'b0;

  always #5 clk_i = ~clk_i;

  isp_seq #(.WORDS(16), .PAGE_WORDS(4), .RD_CYC(2), .PRG_CYC(3), .ERS_CYC(5),
            .UID_VAL(UID), .CID_VAL(CID), .DID_VAL(DID)) i_isp_seq (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .unlock_i, .brownout_i, .app_exec_i, .irq_o
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  // issue a request; returns busy length measured from the trigger edge
  task automatic issue(input logic [6:0] cmd, input logic [31:0] addr, output int cyc);
    logic [31:0] s;
    wr(6'h04, addr);
    wr(6'h0C, {25'd0, cmd});
    wr(6'h10, 32'd1);
    cyc = 0;
    rd(6'h14, s);
    while (s[0]) begin
      cyc++;
      @(negedge clk_i);
      rd(6'h14, s);
    end
  endtask

  task automatic clear_status();
    wr(6'h14, 32'hE);
  endtask

  task automatic read_word(input logic [31:0] addr, output logic [31:0] d);
    int c;
    issue(7'h00, addr, c);
    rd(6'h08, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h14, v); check("R1 reset status", v, 32'h0);
    rd(6'h00, v); check("R1 reset control", v, 32'h0);
    rd(6'h08, v); check("R1 reset data", v, 32'h0);
    rd(6'h10, v); check("R1 reset trigger", v, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int c;
    issue(7'h00, 32'h0, c);
    check("R1 read busy cycles", c, 2);
    rd(6'h08, v); check("R6 erased word read", v, 32'hFFFF_FFFF);
    rd(6'h14, v); check("R10 done sets int flag", v, 32'h4);
    clear_status();
  endtask

  task automatic t_busy_mirror();
    logic [31:0] g, s;
    wr(6'h04, 32'h0); wr(6'h0C, 32'h22);
    wr(6'h10, 32'd1);
    rd(6'h10, g); rd(6'h14, s);
    check("R1 trigger mirrors busy", {g[0], s[0]}, 32'h3);
    repeat (6) @(negedge clk_i);
    rd(6'h10, g); check("R1 trigger self-clears", g, 32'h0);
    clear_status();
  endtask

  task automatic t_program();
    logic [31:0] v;
    int c;
    wr(6'h00, 32'h2);
    wr(6'h08, 32'hF0F0_1234);
    issue(7'h21, 32'h20, c);
    check("R1 program busy cycles", c, 3);
    wr(6'h08, 32'h0FFF_FF0F);
    issue(7'h21, 32'h20, c);
    read_word(32'h20, v); check("R4 program ANDs data", v, 32'h00F0_1204);
    wr(6'h08, 32'h1234_0000);
    issue(7'h21, 32'h30, c);
    wr(6'h08, 32'h0000_5555);
    issue(7'h21, 32'h3C, c);
    read_word(32'h3C, v); check("R3 last word legal", v, 32'h0000_5555);
    rd(6'h14, v); check("R3 last word no fail", v & 32'h2, 32'h0);
    clear_status();
  endtask

  task automatic t_erase();
    logic [31:0] v;
    int c;
    issue(7'h22, 32'h24, c);
    check("R1 erase busy cycles", c, 5);
    read_word(32'h20, v); check("R5 page word erased", v, 32'hFFFF_FFFF);
    read_word(32'h30, v); check("R5 other page kept", v, 32'h1234_0000);
    clear_status();
  endtask

  task automatic t_ids();
    logic [31:0] v;
    int c;
    issue(7'h04, 32'h3, c); rd(6'h08, v); check("R6 unique id", v, UID);
    check("R1 id busy cycles", c, 2);
    issue(7'h0B, 32'h0, c); rd(6'h08, v); check("R6 company id", v, CID);
    issue(7'h0C, 32'h0, c); rd(6'h08, v); check("R6 device id", v, DID);
    rd(6'h14, v); check("R2 id reads no fail", v & 32'h2, 32'h0);
    clear_status();
  endtask

  task automatic t_bad_cmd();
    logic [31:0] v;
    int c;
    wr(6'h08, 32'hAAAA_5555);
    issue(7'h7F, 32'h0, c);
    check("R2 invalid code no busy", c, 0);
    rd(6'h14, v); check("R2 invalid code sets fail", v, 32'h6);
    wr(6'h14, 32'h0);
    rd(6'h14, v); check("R8 fail survives write 0", v & 32'h2, 32'h2);
    wr(6'h14, 32'h2);
    rd(6'h14, v); check("R8 fail cleared by write 1", v, 32'h4);
    clear_status();
    issue(7'h2D, 32'h7, c);
    check("R2 companion code busy", c, 2);
    rd(6'h14, v); check("R2 companion code no fail", v & 32'h2, 32'h0);
    rd(6'h08, v); check("R2 companion code no data change", v, 32'hAAAA_5555);
    clear_status();
  endtask

  task automatic t_align();
    logic [31:0] v;
    int c;
    wr(6'h08, 32'h1111_2222);
    issue(7'h00, 32'h2, c);
    rd(6'h14, v); check("R3 misaligned fails", v & 32'h3, 32'h2);
    rd(6'h08, v); check("R3 misaligned no data change", v, 32'h1111_2222);
    clear_status();
    issue(7'h22, 32'h40, c);
    check("R3 out of range no busy", c, 0);
    rd(6'h14, v); check("R3 out of range fails", v & 32'h2, 32'h2);
    clear_status();
  endtask

  task automatic t_guards();
    logic [31:0] v;
    int c;
    brownout_i = 1'b1;
    wr(6'h08, 32'h0);
    issue(7'h21, 32'h0, c);
    rd(6'h14, v); check("R7 brownout blocks program", v & 32'h3, 32'h2);
    clear_status();
    read_word(32'h0, v); check("R7 brownout read allowed", v, 32'hFFFF_FFFF);
    rd(6'h14, v); check("R7 brownout read no fail", v & 32'h2, 32'h0);
    brownout_i = 1'b0;
    clear_status();
    wr(6'h00, 32'h0);
    app_exec_i = 1'b1;
    wr(6'h08, 32'h0);
    issue(7'h21, 32'h0, c);
    rd(6'h14, v); check("R7 self write blocked", v & 32'h2, 32'h2);
    clear_status();
    read_word(32'h0, v); check("R7 word untouched", v, 32'hFFFF_FFFF);
    app_exec_i = 1'b0;
    clear_status();
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    int c;
    wr(6'h04, 32'h0); wr(6'h0C, 32'h22);
    wr(6'h10, 32'd1);
    wr(6'h04, 32'h0000_0010);
    rd(6'h14, v); check("R9 conflict and fail", v & 32'hB, 32'hB);
    rd(6'h04, v); check("R9 write dropped", v, 32'h0);
    c = 0;
    rd(6'h14, v);
    while (v[0] && c < 20) begin c++; @(negedge clk_i); rd(6'h14, v); end
    check("R9 operation completes", v & 32'hF, 32'hE);
    clear_status();
    rd(6'h14, v); check("R8 all status cleared", v, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    int c;
    wr(6'h00, 32'h1);
    issue(7'h04, 32'h0, c);
    #1; check("R10 irq with enable", {31'd0, irq_o}, 32'h1);
    wr(6'h14, 32'h4);
    #1; check("R10 irq drops with flag", {31'd0, irq_o}, 32'h0);
    wr(6'h00, 32'h0);
    issue(7'h7E, 32'h0, c);
    #1; check("R10 irq masked", {31'd0, irq_o}, 32'h0);
    rd(6'h14, v); check("R10 fail sets int flag", v & 32'h4, 32'h4);
    clear_status();
  endtask

  task automatic t_protect();
    logic [31:0] v;
    unlock_i = 1'b0;
    wr(6'h00, 32'h3);
    rd(6'h00, v); check("R11 locked control ignored", v, 32'h0);
    wr(6'h04, 32'h0); wr(6'h0C, 32'h22);
    wr(6'h10, 32'd1);
    rd(6'h14, v); check("R11 locked trigger ignored", v, 32'h0);
    unlock_i = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_read();
    t_busy_mirror();
    t_program();
    t_erase();
    t_ids();
    t_bad_cmd();
    t_align();
    t_guards();
    t_conflict();
    t_irq();
    t_protect();
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done_flag) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule